// File: doc/BRIEF.md
# PCM Voice Serial Port

This block connects a parallel sample path to a serial PCM voice link of the kind used between a baseband device and an audio codec. In each frame it sends one 16-bit word out and collects one 16-bit word in, most significant bit first. It runs in one of three modes, chosen by a 2-bit mode input.

In the two master modes the block makes the bit clock and the frame sync itself. The system clock must run at four times the bit clock. The two master modes differ only in the sync shape: either a one-bit pulse or a pulse that spans the whole 16-bit data slot. A frame is 256 bit clocks long. The rate pairs this covers are a 2.048 MHz bit clock with an 8 kHz frame and a 4.096 MHz bit clock with a 16 kHz frame. An offset input moves the sync launch by a quarter bit period: later for the short pulse and earlier for the long pulse.

In slave mode the bit clock and sync come in from outside. They pass through two-flop synchronizers, and the block then detects their edges. Output-enable signals tell the pad ring which way to drive the clock and sync pins. Once per frame, after the sixteenth received bit, a single strobe delivers the received word. In the same cycle the strobe takes the word to be sent in the next frame.

Top module: `pcm_port`

## Requirements
- R1: In master modes the bit clock is high for 2 and low for 4−2=2 system cycles, and the frame sync rises once every 1024 system cycles (256 bit clocks).
- R2: Mode codes: 00 is master with short sync, 01 is master with long sync, 10 and 11 are slave. `bclk_oe` and `fsync_oe` are 1 in the master modes and 0 in slave.
- R3: In short-sync master mode the sync is high for exactly one bit period (4 system cycles).
- R4: In long-sync master mode the sync is high for 16 bit periods (64 system cycles).
- R5: With `offset_en` low, the sync rises in the same cycle as the bit clock. With `offset_en` high, the short sync rises one system cycle after a bit-clock rise, and the long sync rises one system cycle before a bit-clock rise. `offset_en` has no effect in slave mode.
- R6: Transmit bits change only on bit-clock falling edges, most significant bit first. Bit 15 starts on the first falling edge after the sync rises.
- R7: In the 240 bit slots after the data slot, `dout` is 0.
- R8: A receive bit is sampled at the bit-clock rising edge in the middle of its bit window, most significant bit first. `rx_valid` pulses for one cycle with the assembled word after the sixteenth bit.
- R9: `tx_ready` pulses in the same cycle as `rx_valid`. The `tx_data` word seen in that cycle is sent in the next frame. The first frame after reset sends zero.
- R10: In slave mode the frame begins at the first detected falling edge of `bclk_i` that follows a detected rising edge of `fsync_i`. Bits are then launched on detected falling edges and sampled on detected rising edges.
- R11: While reset is held, `bclk_o`, `fsync_o`, `dout`, `rx_valid` and `tx_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the master bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Working mode select |
| offset_en | input | 1 | Quarter-bit sync launch offset enable (master only) |
| bclk_i | input | 1 | External bit clock (slave) |
| fsync_i | input | 1 | External frame sync (slave) |
| din | input | 1 | Serial receive data |
| bclk_o | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Drive enable for the bit clock pin |
| fsync_o | output | 1 | Generated frame sync (master) |
| fsync_oe | output | 1 | Drive enable for the sync pin |
| dout | output | 1 | Serial transmit data |
| tx_data | input | 16 | Word to send in the next frame |
| tx_ready | output | 1 | One-cycle strobe: `tx_data` taken |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` updated |

## Verification
The hardest case to reach is the long sync with the offset enabled. There the sync rises in the last quarter-period of the previous frame's final slot, so it sits across the frame boundary. The bench reaches this case by running several whole frames in each master mode and offset setting. It finds every sync edge and bit-clock edge from the ports and measures the offsets and widths in system cycles. In slave mode the bench drives the external clock and sync slowly enough that the synchronizer delay falls inside each half bit. This shows that framing follows the detected edges and that the offset input is ignored. Word hand-over is checked frame to frame: the word taken at one strobe must appear on `dout` in the following frame.

// File: rtl/pcm_pkg.sv
// Shared definitions for the PCM voice serial port.
// Mode codes are decoded by the top module; bit 1 selects slave operation.
package pcm_pkg;
    typedef enum logic [1:0] {
        PCM_MST_SHORT = 2'b00,
        PCM_MST_LONG  = 2'b01,
        PCM_SLV       = 2'b10,
        PCM_SLV_ALT   = 2'b11
    } pcm_mode_e;
endpackage

// File: rtl/pcm_sync_chain.sv
// Multi-stage flop synchronizer for a small bundle of asynchronous inputs.
// Assumes each bit is sampled independently; the bits of the bundle share
// the same latency of STAGES clocks.
module pcm_sync_chain #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the inputs through the stage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pcm_master_timing.sv
// Master-mode clock and sync generator.
// The system clock is four times the bit clock. A 2-bit phase counter marks the
// quarter periods: phases 0-1 bit clock high, phases 2-3 low. A slot counter
// counts bit periods within the frame. The registered outputs show the
// decode of the counter value before each edge, so launch/sample pulses
// line up with the edge at which bclk_o changes.
// Assumes SLOTS > WORD_W. The counter starts in the last slot so that the
// first frame after reset is complete, including an early long sync.
module pcm_master_timing #(
    parameter int unsigned SLOTS  = 256,
    parameter int unsigned WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_mode,
    input  logic offset_en,
    output logic bclk_o,
    output logic fsync_o,
    output logic launch,
    output logic first,
    output logic sample
);
    localparam int unsigned      SLOT_W    = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] LONG_END  = SLOT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_ONE  = SLOT_W'(1);

    logic [1:0]        phase;
    logic [SLOT_W-1:0] slot;
    logic              fs_next;

    // Advance the quarter-period phase and the bit slot within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 2'd0;
            slot  <= LAST_SLOT;
        end else begin
            phase <= phase + 2'd1;
            if (phase == 2'd3) begin
                slot <= (slot == LAST_SLOT) ? '0 : slot + SLOT_ONE;
            end
        end
    end

    // Decode the sync level for the current quarter period.
    always_comb begin
        if (!long_mode) begin
            if (!offset_en) fs_next = (slot == '0);
            else            fs_next = ((slot == '0) && (phase != 2'd0)) ||
                                      ((slot == SLOT_ONE) && (phase == 2'd0));
        end else begin
            if (!offset_en) fs_next = (slot <= LONG_END);
            else            fs_next = ((slot == LAST_SLOT) && (phase == 2'd3)) ||
                                      (slot < LONG_END) ||
                                      ((slot == LONG_END) && (phase != 2'd3));
        end
    end

    // Register the pin levels so they are free of decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_o  <= 1'b0;
            fsync_o <= 1'b0;
        end else begin
            bclk_o  <= ~phase[1];
            fsync_o <= fs_next;
        end
    end

    assign launch = (phase == 2'd2);
    assign first  = launch && (slot == '0);
    assign sample = (phase == 2'd0);
endmodule

// File: rtl/pcm_slave_timing.sv
// Slave-mode edge recovery for an external bit clock and sync.
// Clock, sync and data pass through matched synchronizers, so data is seen
// with the same delay as the clock edges. The external bit clock must be
// slow enough that each half period is longer than the synchronizer delay.
// A frame is armed by a sync rise and begins at the next clock fall.
module pcm_slave_timing #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    input  logic din_i,
    output logic launch,
    output logic first,
    output logic sample,
    output logic din_s
);
    logic [2:0] sq;
    logic       bclk_s, fsync_s;
    logic       bclk_d, fsync_d;
    logic       armed;
    logic       b_rise, b_fall, f_rise;

    pcm_sync_chain #(.W(3), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bclk_i, fsync_i, din_i}),
        .q     (sq)
    );

    assign bclk_s  = sq[2];
    assign fsync_s = sq[1];
    assign din_s   = sq[0];

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            fsync_d <= 1'b0;
        end else begin
            bclk_d  <= bclk_s;
            fsync_d <= fsync_s;
        end
    end

    assign b_rise = bclk_s & ~bclk_d;
    assign b_fall = ~bclk_s & bclk_d;
    assign f_rise = fsync_s & ~fsync_d;

    // Arm on a sync rise; the following clock fall starts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (f_rise) armed <= 1'b1;
        else if (b_fall) armed <= 1'b0;
    end

    assign launch = b_fall;
    assign first  = b_fall & armed;
    assign sample = b_rise;
endmodule

// File: rtl/pcm_shifter.sv
// Word serializer and deserializer shared by all modes.
// 'launch' moves to the next transmit bit, and 'first' restarts at the MSB of
// the held word. 'sample' shifts one receive bit in. After WORD_W bits, the
// received word is presented with a one-cycle strobe, and the next transmit
// word is taken at the same time. Outside the data slot dout is 0 and samples
// are ignored. Assumes launch and sample never coincide and WORD_W >= 3.
module pcm_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              first,
    input  logic              sample,
    input  logic              din,
    input  logic [WORD_W-1:0] tx_data,
    output logic              dout,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int unsigned      CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] IDLE  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LASTB = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bitn;
    logic [WORD_W-2:0] txsr;
    logic [WORD_W-2:0] rxsr;
    logic [WORD_W-1:0] shadow;

    // Transmit side: load on frame start, then step one bit per launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitn <= IDLE;
            txsr <= '0;
            dout <= 1'b0;
        end else if (launch) begin
            if (first) begin
                bitn <= '0;
                txsr <= shadow[WORD_W-2:0];
                dout <= shadow[WORD_W-1];
            end else if (bitn != IDLE) begin
                bitn <= bitn + CNT_W'(1);
                txsr <= {txsr[WORD_W-3:0], 1'b0};
                dout <= (bitn == LASTB) ? 1'b0 : txsr[WORD_W-2];
            end
        end
    end

    // Receive side: assemble bits, then hand over both words on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxsr     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            shadow   <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sample && (bitn != IDLE)) begin
                rxsr <= {rxsr[WORD_W-3:0], din};
                if (bitn == LASTB) begin
                    rx_data  <= {rxsr, din};
                    rx_valid <= 1'b1;
                    shadow   <= tx_data;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_port.sv
// PCM voice serial port top level.
// Selects master timing (clock and sync generated here) or slave timing
// (recovered from the pins) and feeds the chosen events to one shared
// shifter. The mode is assumed to change only while reset is held. The
// pin direction follows the mode through the output enables.
module pcm_port
    import pcm_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SLOTS       = 256,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              offset_en,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              din,
    output logic              bclk_o,
    output logic              bclk_oe,
    output logic              fsync_o,
    output logic              fsync_oe,
    output logic              dout,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    logic is_master, long_mode;
    logic m_bclk, m_fsync, m_launch, m_first, m_sample;
    logic s_launch, s_first, s_sample, s_din;
    logic ev_launch, ev_first, ev_sample, ev_din;

    assign is_master = ~mode[1];
    assign long_mode = (mode == PCM_MST_LONG);

    pcm_master_timing #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .long_mode (long_mode),
        .offset_en (offset_en),
        .bclk_o    (m_bclk),
        .fsync_o   (m_fsync),
        .launch    (m_launch),
        .first     (m_first),
        .sample    (m_sample)
    );

    pcm_slave_timing #(.STAGES(SYNC_STAGES)) u_slv (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk_i),
        .fsync_i (fsync_i),
        .din_i   (din),
        .launch  (s_launch),
        .first   (s_first),
        .sample  (s_sample),
        .din_s   (s_din)
    );

    // Route the timing events of the active mode to the shifter.
    always_comb begin
        if (is_master) begin
            ev_launch = m_launch;
            ev_first  = m_first;
            ev_sample = m_sample;
            ev_din    = din;
        end else begin
            ev_launch = s_launch;
            ev_first  = s_first;
            ev_sample = s_sample;
            ev_din    = s_din;
        end
    end

    pcm_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (ev_launch),
        .first    (ev_first),
        .sample   (ev_sample),
        .din      (ev_din),
        .tx_data  (tx_data),
        .dout     (dout),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    assign tx_ready = rx_valid;
    assign bclk_oe  = is_master;
    assign fsync_oe = is_master;
    assign bclk_o   = is_master & m_bclk;
    assign fsync_o  = is_master & m_fsync;
endmodule

// File: rtl/pcm_port_chk.sv
// Timing checker for pcm_port, attached with bind. It measures sync width and
// frame period with its own counters and checks data launch alignment and
// strobe shape at the ports.
module pcm_port_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned SLOTS  = 256
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       bclk_o,
    input logic       fsync_o,
    input logic       dout,
    input logic       rx_valid
);
    logic [31:0] hi_cnt;
    logic [31:0] per_cnt;
    logic        seen_rise;

    // Count consecutive sync-high cycles and cycles since the last sync rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            per_cnt   <= '0;
            seen_rise <= 1'b0;
        end else begin
            hi_cnt <= fsync_o ? hi_cnt + 32'd1 : 32'd0;
            if (fsync_o && !seen_rise) seen_rise <= 1'b1;
            if ($rose(fsync_o)) per_cnt <= '0;
            else                per_cnt <= per_cnt + 32'd1;
        end
    end

    a_r1_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && $rose(fsync_o) && seen_rise) |-> (per_cnt == SLOTS * 4 - 1));

    a_r3_short_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && $fell(fsync_o)) |-> (hi_cnt == 32'd4));

    a_r4_long_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $fell(fsync_o)) |-> (hi_cnt == WORD_W * 4));

    a_r6_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && !$stable(dout)) |-> $fell(bclk_o));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_port pcm_port_chk #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .bclk_o   (bclk_o),
    .fsync_o  (fsync_o),
    .dout     (dout),
    .rx_valid (rx_valid)
);

// File: tb/sim_pcm_port.sv
// Self-checking bench for pcm_port: every master mode and offset setting over
// several frames, then slave mode driven with an external clock and sync.
module sim_pcm_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        offset_en = 1'b0;
    logic        bclk_i = 1'b0, fsync_i = 1'b0, din = 1'b0;
    logic        bclk_o, bclk_oe, fsync_o, fsync_oe, dout;
    logic [15:0] tx_data = 16'h0;
    logic        tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid;

    int          n_chk = 0, n_fail = 0;
    int          word_idx = 0, rx_seen = 0;
    logic [15:0] pend_tx = 16'h0, exp_rx = 16'h0;
    bit          done = 0;

    always #10 clk = ~clk;

    pcm_port u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .offset_en(offset_en),
        .bclk_i(bclk_i), .fsync_i(fsync_i), .din(din),
        .bclk_o(bclk_o), .bclk_oe(bclk_oe), .fsync_o(fsync_o), .fsync_oe(fsync_oe),
        .dout(dout), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    function automatic logic [15:0] pat(input int i);
        case (i % 6)
            0:       return 16'hFFFF;
            1:       return 16'h0000;
            2:       return 16'h8001;
            3:       return 16'h7FFE;
            default: return 16'hA5C3 ^ 16'(i * 4919);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Word hand-over monitor (R8, R9).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            chk(rx_data == exp_rx, "R8", "received word", int'(rx_data), int'(exp_rx));
            chk(tx_ready == 1'b1, "R9", "tx_ready with rx_valid", int'(tx_ready), 1);
            pend_tx  = tx_data;
            tx_data  = pat(word_idx);
            word_idx = word_idx + 1;
            rx_seen  = rx_seen + 1;
        end
    end

    task automatic do_reset(input logic [1:0] md, input logic off);
        rst_n = 1'b0; mode = md; offset_en = off;
        bclk_i = 1'b0; fsync_i = 1'b0; din = 1'b0;
        pend_tx = 16'h0; tx_data = pat(word_idx); word_idx++;
        rx_seen = 0;
        repeat (4) @(negedge clk);
        chk(!bclk_o && !fsync_o && !dout && !rx_valid && !tx_ready, "R11",
            "outputs low in reset",
            int'({bclk_o, fsync_o, dout, rx_valid, tx_ready}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_master(input logic [1:0] md, input logic off, input int frames);
        int cyc, last_fr, last_br, hi, bitk, seen;
        bit pend, zero_ok, clk_ok, islong;
        logic b, f, d, pb, pf;
        logic [15:0] rxw, txe;
        islong = (md == 2'b01);
        do_reset(md, off);
        chk(bclk_oe && fsync_oe, "R2", "master drives pins", int'({bclk_oe, fsync_oe}), 3);
        cyc = 0; last_fr = -1; last_br = -1; hi = 0; bitk = -1; seen = 0;
        pend = 0; zero_ok = 1; clk_ok = 1; pb = 1'b0; pf = 1'b0;
        rxw = 16'h0; txe = 16'h0;
        while (seen <= frames) begin
            @(negedge clk);
            b = bclk_o; f = fsync_o; d = dout;
            if (b && !pb) begin
                if (last_br >= 0 && cyc - last_br != 4) clk_ok = 0;
                last_br = cyc;
            end
            if (pend) begin
                chk(b && !pb, "R5", "long offset: bclk rises a cycle after sync",
                    int'(b), 1);
                pend = 0;
            end
            if (f && !pf) begin
                if (last_fr >= 0)
                    chk(cyc - last_fr == 1024, "R1", "frame period", cyc - last_fr, 1024);
                last_fr = cyc;
                if (!off)         chk(b && !pb, "R5", "sync aligned to bclk rise", int'(b), 1);
                else if (!islong) chk(last_br == cyc - 1, "R5", "short offset: sync after bclk rise",
                                      cyc - last_br, 1);
                else              pend = 1;
                if (seen > 0) chk(zero_ok, "R7", "zero after data slot", int'(zero_ok), 1);
                seen++;
                zero_ok = 1;
                txe = pend_tx;
                rxw = pat(seen * 7 + int'(md));
                exp_rx = rxw;
                bitk = -1;
            end
            if (!f && pf)
                chk(hi == (islong ? 64 : 4), islong ? "R4" : "R3", "sync width",
                    hi, islong ? 64 : 4);
            hi = f ? hi + 1 : 0;
            if (!b && pb && seen > 0) begin
                bitk++;
                din = (bitk < 16) ? rxw[15 - bitk] : 1'b0;
            end
            if (b && !pb && bitk >= 0) begin
                if (bitk < 16) chk(d == txe[15 - bitk], "R6", "transmit bit",
                                   int'(d), int'(txe[15 - bitk]));
                else if (d != 1'b0) zero_ok = 0;
            end
            pb = b; pf = f; cyc++;
        end
        chk(clk_ok, "R1", "bit clock 2 high 2 low", int'(clk_ok), 1);
        chk(rx_seen == frames, "R8", "strobes per run", rx_seen, frames);
    endtask

    task automatic run_slave(input logic [1:0] md, input logic off, input int frames);
        logic [15:0] rxw, txe;
        do_reset(md, off);
        chk(!bclk_oe && !fsync_oe, "R2", "slave releases pins", int'({bclk_oe, fsync_oe}), 0);
        repeat (8) @(negedge clk);
        for (int fr = 0; fr < frames; fr++) begin
            txe = pend_tx;
            rxw = pat(fr * 5 + 3);
            exp_rx = rxw;
            for (int s = 0; s < 32; s++) begin
                bclk_i = 1'b1; fsync_i = (s == 0);
                repeat (4) @(negedge clk);
                bclk_i = 1'b0;
                din = (s < 16) ? rxw[15 - s] : 1'b0;
                repeat (4) @(negedge clk);
                if (s < 16)
                    chk(dout == txe[15 - s], off ? "R5" : "R10",
                        "slave transmit bit (offset ignored in slave)",
                        int'(dout), int'(txe[15 - s]));
                else if (s == 20)
                    chk(dout == 1'b0, "R7", "slave zero after data slot", int'(dout), 0);
            end
        end
        chk(rx_seen == frames, "R10", "slave strobes per run", rx_seen, frames);
    endtask

    initial begin
        run_master(2'b00, 1'b0, 3);
        run_master(2'b00, 1'b1, 3);
        run_master(2'b01, 1'b0, 3);
        run_master(2'b01, 1'b1, 3);
        run_slave(2'b10, 1'b0, 3);
        run_slave(2'b11, 1'b1, 3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule